// File: doc/BRIEF.md
# Pipelined Microprogram Sequencer with Wired-OR Branching

This block steps through a microprogram held in a small internal control store. Every control word carries the address of its successor, and branching needs no adder or multiplexer: external condition sources can only set bits, and they OR ones into the low bits of that successor field. A branch pair is therefore placed with the "false" word at an even address and the "true" word at the next odd address. The word that one condition sets is the word that runs, so the branch logic is the OR alone.

Control-store access is pipelined. An address that appears on the successor bus is read in the next cycle and executes in the cycle after that. Each control word has two 4-bit function fields. Codes 0 to 7 are shared by every task. Codes 8 to 15 only take effect while the owning task holds the processor. The decoded strobes come from a register, so they stay steady for the whole execution cycle and never follow a field that changes near the clock edge.

A stall input freezes the pipeline for one to three cycles, for example while a memory reference is in progress. During a stall no strobe is issued. The clock that drives the block keeps running, and a stall input held for longer is capped so that the sequencer moves on.

Top module: `useq_core`

## Requirements
- R1: While reset is applied, and in the first cycle after it is released, fetch_addr_o and exec_addr_o are 0 and all four strobe vectors are 0.
- R2: The control word at address a holds a successor field equal to ((a with bit 0 cleared) + 6) mod 1024, a first function field equal to a[3:0] and a second function field equal to a[7:4].
- R3: The successor bus next_addr_o equals the successor field of the word at fetch_addr_o with br_or_i ORed into bits 4:0. Bits 9:5 are unaffected, and a branch input never clears a bit. On every advancing edge, fetch_addr_o takes the value on the bus.
- R4: When br_or_i[0] is 1 and the successor field is even, the next fetch address is that field plus one, so the true target is the odd neighbour of the false target.
- R5: An address on next_addr_o becomes fetch_addr_o after the next advancing edge and exec_addr_o after the advancing edge that follows.
- R6: A function code c from 1 to 7 sets bit c of its shared strobe vector (f1_shared_o for the first field, f2_shared_o for the second) during the execution cycle of that word, whatever the value of task_act_i. Code 0 sets no strobe.
- R7: A function code c from 8 to 15 sets bit c-8 of its task strobe vector during the execution cycle only if task_act_i was 1 in the preceding cycle (the fetch cycle). Otherwise that strobe vector stays 0.
- R8: The strobe outputs change only at clock edges. Within each field, at most one bit across the shared and task vectors is set.
- R9: When stall_i is 1 at an edge and the stall cap has not been reached, fetch_addr_o and exec_addr_o hold their values and all strobes are 0 in the following cycle.
- R10: After 3 consecutive held edges, the next edge advances even if stall_i is still 1, and the stall count then starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with clk |
| stall_i | input | 1 | Freezes the pipeline at the next edge (capped at 3 edges) |
| br_or_i | input | 5 | Branch condition bits ORed into the low successor bits |
| task_act_i | input | 1 | Owning task holds the processor; qualifies codes 8 to 15 |
| next_addr_o | output | 10 | Successor bus: address to be fetched next |
| fetch_addr_o | output | 10 | Address being read from the control store |
| exec_addr_o | output | 10 | Address of the word now executing |
| f1_shared_o | output | 8 | Shared strobes from the first function field |
| f1_task_o | output | 8 | Task strobes from the first function field |
| f2_shared_o | output | 8 | Shared strobes from the second function field |
| f2_task_o | output | 8 | Task strobes from the second function field |

## Verification
An address driven onto the successor bus is due on fetch_addr_o one edge later and on exec_addr_o two edges later. The strobes of that word appear together with its exec_addr_o, and a held edge repeats the previous addresses with the strobes cleared. For every cycle the stimulus task pushes the expected fetch address, execution address and strobes due after the next rising edge. The monitor pops that entry a quarter period after the edge and checks the strobes again three quarters into the cycle, after the inputs have changed, to confirm they are steady.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Width of each function field and the size of each half of its code space.
  localparam int FN_W    = 4;
  localparam int FN_HALF = 2 ** (FN_W - 1);

  typedef struct packed {
    logic [FN_HALF-1:0] tsk;
    logic [FN_HALF-1:0] shared;
  } fn_strb_t;

  // Upper half of the code space is task qualified; code 0 is a no-op.
  function automatic fn_strb_t fn_decode(input logic [FN_W-1:0] code,
                                         input logic            act);
    fn_strb_t r;
    r = '0;
    if (code[FN_W-1]) begin
      if (act) r.tsk[code[FN_W-2:0]] = 1'b1;
    end else if (code != '0) begin
      r.shared[code[FN_W-2:0]] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/useq_store.sv
module useq_store
  import useq_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int STRIDE = 6
) (
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [ADDR_W+2*FN_W-1:0]     rd_word
);

  localparam int DEPTH  = 2 ** ADDR_W;
  localparam int WORD_W = ADDR_W + 2 * FN_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] EVEN = ~ADDR_W'(1);

  logic [WORD_W-1:0] rom [DEPTH];

  // Contents are computed per address: even-aligned successor plus stride,
  // function fields taken from the low address bits.
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [ADDR_W-1:0] A = ADDR_W'(i);
    assign rom[i] = {(A & EVEN) + STEP, A[2*FN_W-1:FN_W], A[FN_W-1:0]};
  end

  assign rd_word = rom[rd_addr];

endmodule

// File: rtl/useq_stall.sv
module useq_stall #(
  parameter int MAX_STALL = 3,
  localparam int CNT_W    = $clog2(MAX_STALL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall,
  output logic             adv,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_STALL);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    adv   = !stall || (cnt_q == CAP);
    cnt_d = adv ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/useq_fndec.sv
module useq_fndec
  import useq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic               task_act,
  input  logic [FN_W-1:0]    f1_code,
  input  logic [FN_W-1:0]    f2_code,
  output logic [FN_HALF-1:0] f1_shared,
  output logic [FN_HALF-1:0] f1_task,
  output logic [FN_HALF-1:0] f2_shared,
  output logic [FN_HALF-1:0] f2_task
);

  fn_strb_t f1_q, f1_d, f2_q, f2_d;

  // Decode the word entering execution; a held edge issues nothing.
  always_comb begin
    f1_d = '0;
    f2_d = '0;
    if (adv) begin
      f1_d = fn_decode(f1_code, task_act);
      f2_d = fn_decode(f2_code, task_act);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f1_q <= '0;
      f2_q <= '0;
    end else begin
      f1_q <= f1_d;
      f2_q <= f2_d;
    end
  end

  assign f1_shared = f1_q.shared;
  assign f1_task   = f1_q.tsk;
  assign f2_shared = f2_q.shared;
  assign f2_task   = f2_q.tsk;

endmodule

// File: rtl/useq_core.sv
module useq_core
  import useq_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int BR_W      = 5,
  parameter int STRIDE    = 6,
  parameter int MAX_STALL = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall_i,
  input  logic [BR_W-1:0]    br_or_i,
  input  logic               task_act_i,
  output logic [ADDR_W-1:0]  next_addr_o,
  output logic [ADDR_W-1:0]  fetch_addr_o,
  output logic [ADDR_W-1:0]  exec_addr_o,
  output logic [FN_HALF-1:0] f1_shared_o,
  output logic [FN_HALF-1:0] f1_task_o,
  output logic [FN_HALF-1:0] f2_shared_o,
  output logic [FN_HALF-1:0] f2_task_o
);

  localparam int WORD_W = ADDR_W + 2 * FN_W;
  localparam int CNT_W  = $clog2(MAX_STALL + 1);

  // Reset: asserted at once, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  logic             adv;
  logic [CNT_W-1:0] stall_cnt;

  useq_stall #(.MAX_STALL(MAX_STALL)) u_stall (
    .clk   (clk),
    .rst_n (rst_q_n),
    .stall (stall_i),
    .adv   (adv),
    .cnt   (stall_cnt)
  );

  logic [ADDR_W-1:0] fetch_q, fetch_d, exec_q, exec_d;
  logic [WORD_W-1:0] rd_word;
  logic [ADDR_W-1:0] succ_field, next_bus;
  logic [FN_W-1:0]   f1_code, f2_code;

  useq_store #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_store (
    .rd_addr (fetch_q),
    .rd_word (rd_word)
  );

  // Wired-OR successor: condition bits can only set low address bits.
  always_comb begin
    succ_field = rd_word[WORD_W-1 -: ADDR_W];
    f2_code    = rd_word[2*FN_W-1:FN_W];
    f1_code    = rd_word[FN_W-1:0];
    next_bus   = succ_field | {{(ADDR_W-BR_W){1'b0}}, br_or_i};
  end

  always_comb begin
    fetch_d = fetch_q;
    exec_d  = exec_q;
    if (adv) begin
      fetch_d = next_bus;
      exec_d  = fetch_q;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      fetch_q <= '0;
      exec_q  <= '0;
    end else begin
      fetch_q <= fetch_d;
      exec_q  <= exec_d;
    end
  end

  useq_fndec u_fndec (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .adv       (adv),
    .task_act  (task_act_i),
    .f1_code   (f1_code),
    .f2_code   (f2_code),
    .f1_shared (f1_shared_o),
    .f1_task   (f1_task_o),
    .f2_shared (f2_shared_o),
    .f2_task   (f2_task_o)
  );

  assign next_addr_o  = next_bus;
  assign fetch_addr_o = fetch_q;
  assign exec_addr_o  = exec_q;

endmodule

// File: rtl/useq_core_chk.sv
module useq_core_chk #(
  parameter int ADDR_W    = 10,
  parameter int BR_W      = 5,
  parameter int MAX_STALL = 3,
  parameter int HALF      = 8,
  localparam int CNT_W    = $clog2(MAX_STALL + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              adv,
  input logic [CNT_W-1:0]  stall_cnt,
  input logic [BR_W-1:0]   br_or,
  input logic              task_act,
  input logic [ADDR_W-1:0] next_addr,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic [ADDR_W-1:0] exec_addr,
  input logic [HALF-1:0]   f1_shared,
  input logic [HALF-1:0]   f1_task,
  input logic [HALF-1:0]   f2_shared,
  input logic [HALF-1:0]   f2_task
);

  assert_bus_keeps_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((next_addr[BR_W-1:0] & br_or) == br_or));

  assert_fetch_takes_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (fetch_addr == $past(next_addr)));

  assert_true_is_odd_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_or[0] |-> next_addr[0]);

  assert_exec_follows_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (exec_addr == $past(fetch_addr)));

  assert_task_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((f1_task != '0) || (f2_task != '0)) |-> $past(task_act));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0({f1_shared, f1_task}) && $onehot0({f2_shared, f2_task})));

  assert_hold_on_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> ($stable(fetch_addr) && $stable(exec_addr) &&
              ({f1_shared, f1_task, f2_shared, f2_task} == '0)));

  assert_stall_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt == CNT_W'(MAX_STALL)) |=> (stall_cnt == '0));

endmodule

bind useq_core useq_core_chk #(
  .ADDR_W(ADDR_W), .BR_W(BR_W), .MAX_STALL(MAX_STALL), .HALF(useq_pkg::FN_HALF)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_q_n),
  .adv        (adv),
  .stall_cnt  (stall_cnt),
  .br_or      (br_or_i),
  .task_act   (task_act_i),
  .next_addr  (next_addr_o),
  .fetch_addr (fetch_addr_o),
  .exec_addr  (exec_addr_o),
  .f1_shared  (f1_shared_o),
  .f1_task    (f1_task_o),
  .f2_shared  (f2_shared_o),
  .f2_task    (f2_task_o)
);

// File: tb/useq_core_bench.sv
module useq_core_bench;

  localparam int PERIOD = 10;
  localparam int AW     = 10;
  localparam int BW     = 5;
  localparam int STRIDE = 6;
  localparam int MAXS   = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stall_i;
  logic [BW-1:0] br_or_i;
  logic          task_act_i;
  logic [AW-1:0] next_addr_o, fetch_addr_o, exec_addr_o;
  logic [7:0]    f1_shared_o, f1_task_o, f2_shared_o, f2_task_o;

  always #(PERIOD/2) clk = ~clk;

  useq_core u_useq_core (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .br_or_i(br_or_i),
    .task_act_i(task_act_i), .next_addr_o(next_addr_o),
    .fetch_addr_o(fetch_addr_o), .exec_addr_o(exec_addr_o),
    .f1_shared_o(f1_shared_o), .f1_task_o(f1_task_o),
    .f2_shared_o(f2_shared_o), .f2_task_o(f2_task_o)
  );

  typedef struct {
    logic [AW-1:0] fetch;
    logic [AW-1:0] exec;
    logic [31:0]   strb;
    string         tag;
    string         stag;
  } exp_t;

  exp_t          q[$];
  int            n_chk  = 0;
  int            n_fail = 0;
  logic [AW-1:0] m_fetch, m_exec;
  int            m_cnt;
  bit            done = 0;

  // Successor field of a word, from R2.
  function automatic logic [AW-1:0] succ(input logic [AW-1:0] a);
    return ((a & ~AW'(1)) + AW'(STRIDE));
  endfunction

  // {task, shared} strobe pattern for one field, from R6 and R7.
  function automatic logic [15:0] dec(input logic [3:0] c, input bit ta);
    logic [15:0] r = '0;
    if (c >= 4'd8) begin
      if (ta) r[c] = 1'b1;
    end else if (c != 4'd0) begin
      r[c] = 1'b1;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] strobes();
    return {f2_task_o, f2_shared_o, f1_task_o, f1_shared_o};
  endfunction

  // Driver: sets inputs for one cycle and queues what the next edge yields.
  task automatic step(input bit st, input logic [BW-1:0] br, input bit ta,
                      input string tag);
    exp_t        e;
    logic [15:0] d1, d2;
    @(negedge clk);
    stall_i = st; br_or_i = br; task_act_i = ta;
    if (!st || m_cnt == MAXS) begin
      d1      = dec(m_fetch[3:0], ta);
      d2      = dec(m_fetch[7:4], ta);
      e.strb  = {d2[15:8], d2[7:0], d1[15:8], d1[7:0]};
      m_exec  = m_fetch;
      m_fetch = succ(m_fetch) | AW'(br);
      m_cnt   = 0;
      e.stag  = ta ? "R6" : "R7";
    end else begin
      e.strb  = '0;
      m_cnt++;
      e.stag  = "R9";
    end
    e.fetch = m_fetch;
    e.exec  = m_exec;
    e.tag   = tag;
    q.push_back(e);
  endtask

  // Monitor: pops one expectation per edge, a quarter period after it.
  initial begin
    exp_t        e;
    logic [31:0] snap;
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(e.tag, "fetch_addr", 32'(fetch_addr_o), 32'(e.fetch));
        chk("R5", "exec_addr", 32'(exec_addr_o), 32'(e.exec));
        chk(e.stag, "strobes", strobes(), e.strb);
        chk("R3", "next_addr", 32'(next_addr_o),
            32'(succ(fetch_addr_o) | AW'(br_or_i)));
        snap = strobes();
        #(PERIOD/2);
        chk("R8", "strobes steady", strobes(), snap);
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; stall_i = 1'b0; br_or_i = '0; task_act_i = 1'b1;
    m_fetch = '0; m_exec = '0; m_cnt = 0;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    chk("R1", "fetch in reset", 32'(fetch_addr_o), 32'd0);
    chk("R1", "exec in reset", 32'(exec_addr_o), 32'd0);
    chk("R1", "strobes in reset", strobes(), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #(PERIOD/4);
    chk("R1", "fetch after release", 32'(fetch_addr_o), 32'd0);
    chk("R1", "strobes after release", strobes(), 32'd0);

    // R2: straight-line sequence, no branch bits.
    for (int i = 0; i < 24; i++) step(1'b0, '0, 1'b1, "R2");
    // R4: true condition on the LSB picks the odd neighbour.
    for (int i = 0; i < 12; i++) step(1'b0, 5'b00001, 1'b1, "R4");
    // R3: arbitrary branch bits, task active.
    for (int i = 0; i < 60; i++) step(1'b0, BW'($urandom), 1'b1, "R3");
    // R7: task not active while task codes come through.
    for (int i = 0; i < 60; i++) step(1'b0, BW'($urandom), 1'b0, "R7");
    // R9: stalls of one, two and three cycles.
    for (int n = 1; n <= 3; n++) begin
      for (int s = 0; s < n; s++) step(1'b1, BW'($urandom), 1'b1, "R9");
      for (int i = 0; i < 3; i++) step(1'b0, BW'($urandom), 1'b1, "R9");
    end
    // R10: stall held far past the cap.
    for (int s = 0; s < 9; s++) step(1'b1, BW'($urandom), s[0], "R10");
    for (int i = 0; i < 40; i++)
      step(($urandom % 3) == 0, BW'($urandom), 1'($urandom), "R10");

    @(negedge clk); stall_i = 1'b0;
    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule